// File: doc/BRIEF.md
# Byte-Addressable Load/Store Stage

This block is the memory-access stage of a small 16-bit pipelined core. Each cycle it accepts at most one decoded operation, made up of an opcode, a byte-extension mode bit, a base register value, a sign-extended immediate and store data. From these it forms an effective address and runs the access against a private 256-byte data memory. The memory is stored as two 8-bit lanes so that it can be inferred as block RAM.

The block supports four operations. A word load returns both bytes of the aligned word. A byte load returns one byte and widens it to 16 bits, with zero or sign extension chosen by the mode bit. A word store writes a register value. A store-immediate uses the base register alone as the address and writes the immediate. The load result is registered and goes to write-back one cycle after the operation is presented. Every other opcode passes through the stage without touching memory.

Top module: `lsu_mem_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `load_valid_q` is 0 and `load_data_q` is 0.
- R2: An accepted opcode 4'b0101 (word load) gives effective address (base_val + imm_val) mod 256. One cycle later `load_data_q` is {byte[A|1], byte[A&~1]}, where A is that address, so bit 0 is ignored and the word is little-endian.
- R3: An accepted opcode 4'b0110 with `byte_sext` = 0 returns the byte at (base_val + imm_val) mod 256 in bits 7:0 one cycle later, with bits 15:8 cleared.
- R4: An accepted opcode 4'b0110 with `byte_sext` = 1 returns that byte in bits 7:0 one cycle later, with bits 15:8 copies of its bit 7.
- R5: An accepted opcode 4'b0111 (word store) writes store_val[7:0] to the even byte and store_val[15:8] to the odd byte of the word that holds (base_val + imm_val) mod 256.
- R6: An accepted opcode 4'b1111 (store-immediate) writes {8'h00, imm_val[7:0]} to the word that holds base_val mod 256. No offset is added.
- R7: Memory changes only for an accepted word store or store-immediate. An operation with `op_valid` low, or any other opcode, leaves every byte unchanged and gives `load_valid_q` = 0 on the next cycle.
- R8: `load_valid_q` is 1 exactly in the cycle after an accepted load. `load_data_q` is 0 whenever `load_valid_q` is 0.
- R9: Address arithmetic wraps modulo 256. A sum above 255 addresses the low end of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Decoded opcode |
| byte_sext | input | 1 | Byte load mode: 0 zero-extends, 1 sign-extends |
| base_val | input | 16 | Base register value (the address for store-immediate) |
| imm_val | input | 16 | Sign-extended immediate |
| store_val | input | 16 | Register value for a word store |
| load_valid_q | output | 1 | Registered load result valid |
| load_data_q | output | 16 | Registered, extended load result |

## Verification
Stores finish at the clock edge where they are presented. A load presented in cycle N reports its valid flag and its data after the edge that ends cycle N, and nothing is reported earlier or later. The bench drives every operation on a falling edge. On the next falling edge it compares both outputs against the value that a behavioural byte-array model predicted when that operation was issued. The model takes its load data before it applies any write, so a load issued in the cycle directly after a store to the same word must return the new data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam logic [3:0] OPC_LDW = 4'b0101;
  localparam logic [3:0] OPC_LDB = 4'b0110;
  localparam logic [3:0] OPC_STW = 4'b0111;
  localparam logic [3:0] OPC_STI = 4'b1111;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LDW   = 2'd1,
    ACC_LDB   = 2'd2,
    ACC_STORE = 2'd3
  } lsu_acc_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int SVIMM_W = 8,
  parameter int LANES   = DATA_W / 8
) (
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] store_val,
  output lsu_acc_e          acc,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] wr_data
);

  localparam int PAD_W = DATA_W - SVIMM_W;

  logic [ADDR_W-1:0] offset_sum;

  assign offset_sum = base_val[ADDR_W-1:0] + imm_val[ADDR_W-1:0];

  always_comb begin
    acc      = ACC_NONE;
    eff_addr = offset_sum;
    wr_data  = store_val;
    if (op_valid) begin
      case (op_code)
        OPC_LDW: acc = ACC_LDW;
        OPC_LDB: acc = ACC_LDB;
        OPC_STW: acc = ACC_STORE;
        OPC_STI: begin
          acc      = ACC_STORE;
          eff_addr = base_val[ADDR_W-1:0];
          wr_data  = {{PAD_W{1'b0}}, imm_val[SVIMM_W-1:0]};
        end
        default: acc = ACC_NONE;
      endcase
    end
  end

  assign lane_we = (acc == ACC_STORE) ? {LANES{1'b1}} : {LANES{1'b0}};

endmodule

// File: rtl/lsu_byte_ram.sv
module lsu_byte_ram #(
  parameter int LANES   = 2,
  parameter int WORDS_W = 7
) (
  input  logic               clk,
  input  logic [LANES-1:0]   lane_we,
  input  logic               rd_en,
  input  logic [WORDS_W-1:0] word_idx,
  input  logic [LANES*8-1:0] wr_data,
  output logic [LANES*8-1:0] rd_data_q
);

  localparam int WORDS = 1 << WORDS_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) bank[word_idx] <= wr_data[g*8 +: 8];
      if (rd_en) rd_q <= bank[word_idx];
    end

    assign rd_data_q[g*8 +: 8] = rd_q;
  end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  lsu_acc_e           acc,
  input  logic               byte_sext,
  input  logic [LANE_W-1:0]  lane_sel,
  input  logic [LANES*8-1:0] ram_q,
  output logic               load_valid_q,
  output logic [LANES*8-1:0] load_data_q
);

  localparam int DW = LANES * 8;

  logic              vld_q, byte_q, sext_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        pick;
  logic [DW-1:0]     widened;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      byte_q <= 1'b0;
      sext_q <= 1'b0;
      lane_q <= '0;
    end else begin
      vld_q  <= (acc == ACC_LDW) || (acc == ACC_LDB);
      byte_q <= (acc == ACC_LDB);
      sext_q <= byte_sext;
      lane_q <= lane_sel;
    end
  end

  assign pick    = ram_q[lane_q*8 +: 8];
  assign widened = byte_q ? {{(DW-8){sext_q & pick[7]}}, pick} : ram_q;

  assign load_valid_q = vld_q;
  assign load_data_q  = vld_q ? widened : '0;

endmodule

// File: rtl/lsu_mem_stage.sv
module lsu_mem_stage
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_BYTES = 256,
  parameter int SVIMM_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              byte_sext,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] store_val,
  output logic              load_valid_q,
  output logic [DATA_W-1:0] load_data_q
);

  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int WORDS_W = ADDR_W - LANE_W;

  lsu_acc_e          acc;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] ram_q;
  logic              rd_en;

  lsu_addr_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SVIMM_W(SVIMM_W), .LANES(LANES)
  ) u_agen (
    .op_valid(op_valid), .op_code(op_code), .base_val(base_val),
    .imm_val(imm_val), .store_val(store_val), .acc(acc),
    .eff_addr(eff_addr), .lane_we(lane_we), .wr_data(wr_data)
  );

  assign rd_en = (acc == ACC_LDW) || (acc == ACC_LDB);

  lsu_byte_ram #(
    .LANES(LANES), .WORDS_W(WORDS_W)
  ) u_ram (
    .clk(clk), .lane_we(lane_we), .rd_en(rd_en),
    .word_idx(eff_addr[ADDR_W-1:LANE_W]), .wr_data(wr_data),
    .rd_data_q(ram_q)
  );

  lsu_load_align #(
    .LANES(LANES), .LANE_W(LANE_W)
  ) u_align (
    .clk(clk), .rst(rst), .acc(acc), .byte_sext(byte_sext),
    .lane_sel(eff_addr[LANE_W-1:0]), .ram_q(ram_q),
    .load_valid_q(load_valid_q), .load_data_q(load_data_q)
  );

endmodule

// File: rtl/lsu_mem_stage_chk.sv
module lsu_mem_stage_chk #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic              byte_sext,
  input logic [LANES-1:0]  lane_we,
  input logic              load_valid_q,
  input logic [DATA_W-1:0] load_data_q
);

  logic is_load, is_store;
  assign is_load  = op_valid && (op_code == 4'b0101 || op_code == 4'b0110);
  assign is_store = op_valid && (op_code == 4'b0111 || op_code == 4'b1111);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!load_valid_q && load_data_q == '0));

  assert_load_reports_R8: assert property (@(posedge clk) disable iff (rst)
    is_load |=> load_valid_q);

  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !is_load |=> !load_valid_q);

  assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !load_valid_q |-> load_data_q == '0);

  assert_zero_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'b0110 && !byte_sext) |=> load_data_q[DATA_W-1:8] == '0);

  assert_sign_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'b0110 && byte_sext)
      |=> load_data_q[DATA_W-1:8] == {(DATA_W-8){load_data_q[7]}});

  assert_write_only_store_R7: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |-> is_store);

  assert_store_full_word_R5: assert property (@(posedge clk) disable iff (rst)
    is_store |-> (&lane_we));

endmodule

bind lsu_mem_stage lsu_mem_stage_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .byte_sext(byte_sext), .lane_we(lane_we),
  .load_valid_q(load_valid_q), .load_data_q(load_data_q)
);

// File: tb/lsu_mem_stage_tb.sv
module lsu_mem_stage_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        byte_sext;
  logic [15:0] base_val, imm_val, store_val;
  logic        load_valid_q;
  logic [15:0] load_data_q;

  always #10 clk = ~clk;

  lsu_mem_stage u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .byte_sext(byte_sext), .base_val(base_val), .imm_val(imm_val),
    .store_val(store_val), .load_valid_q(load_valid_q), .load_data_q(load_data_q)
  );

  logic [7:0]  model [256];
  logic        exp_v;
  logic [15:0] exp_d;
  string       exp_tag;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  task automatic compare();
    n_chk++;
    if (load_valid_q !== exp_v || load_data_q !== exp_d) begin
      n_bad++;
      $display("FAIL %s/R8: valid=%0b data=%h expected valid=%0b data=%h",
               exp_tag, load_valid_q, load_data_q, exp_v, exp_d);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] op, input bit mode,
                      input logic [15:0] b, input logic [15:0] im,
                      input logic [15:0] sd, input string tag);
    logic [7:0] ea;
    logic [7:0] by;
    @(negedge clk);
    compare();
    op_valid = v; op_code = op; byte_sext = mode;
    base_val = b; imm_val = im; store_val = sd;
    ea = (op == 4'b1111) ? b[7:0] : 8'(b + im);
    exp_v = 1'b0; exp_d = 16'h0000; exp_tag = "R7";
    if (v && op == 4'b0101) begin
      exp_v = 1'b1; exp_tag = "R2";
      exp_d = {model[{ea[7:1], 1'b1}], model[{ea[7:1], 1'b0}]};
    end else if (v && op == 4'b0110) begin
      by = model[ea];
      exp_v = 1'b1; exp_tag = mode ? "R4" : "R3";
      exp_d = mode ? {{8{by[7]}}, by} : {8'h00, by};
    end else if (v && op == 4'b0111) begin
      exp_tag = "R5";
      model[{ea[7:1], 1'b0}] = sd[7:0];
      model[{ea[7:1], 1'b1}] = sd[15:8];
    end else if (v && op == 4'b1111) begin
      exp_tag = "R6";
      model[{ea[7:1], 1'b0}] = im[7:0];
      model[{ea[7:1], 1'b1}] = 8'h00;
    end
    if (tag != "") exp_tag = tag;
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = 4'h0; byte_sext = 1'b0;
    base_val = '0; imm_val = '0; store_val = '0;
    exp_v = 1'b0; exp_d = 16'h0000; exp_tag = "R1";
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst = 1'b0;
    // fill every word so the model is fully known (R5)
    for (int w = 0; w < 128; w++)
      step(1, 4'b0111, 0, 16'(2 * w), 16'h0000, 16'($urandom), "R5");
    // word load at odd address aligns down (R2)
    step(1, 4'b0101, 0, 16'h0011, 16'h0000, 16'h0, "R2");
    step(1, 4'b0101, 0, 16'h0100, 16'hFF11, 16'h0, "R2");
    // byte loads with both extension modes (R3, R4)
    step(1, 4'b0111, 0, 16'h0020, 16'h0000, 16'h80F3, "R5");
    step(1, 4'b0110, 0, 16'h0020, 16'h0000, 16'h0, "R3");
    step(1, 4'b0110, 0, 16'h0021, 16'h0000, 16'h0, "R3");
    step(1, 4'b0110, 1, 16'h0021, 16'h0000, 16'h0, "R4");
    step(1, 4'b0110, 1, 16'h0010, 16'h0010, 16'h0, "R4");
    step(1, 4'b0110, 1, 16'h0022, 16'hFFFF, 16'h0, "R4");
    // store-immediate ignores the offset (R6)
    step(1, 4'b1111, 0, 16'h0031, 16'hFFAB, 16'hDEAD, "R6");
    step(1, 4'b0101, 0, 16'h0030, 16'h0000, 16'h0, "R6");
    step(1, 4'b0101, 0, 16'h0000, 16'hFFAB, 16'h0, "R6");
    // wrap-around of address arithmetic (R9)
    step(1, 4'b0101, 0, 16'hFFFE, 16'h0003, 16'h0, "R9");
    step(1, 4'b0110, 0, 16'h00FF, 16'h0002, 16'h0, "R9");
    // blocked stores and other opcodes leave memory alone (R7)
    step(0, 4'b0111, 0, 16'h0040, 16'h0000, 16'h1234, "R7");
    step(1, 4'b0000, 0, 16'h0040, 16'h0000, 16'h5678, "R7");
    step(1, 4'b0011, 0, 16'h0040, 16'h0000, 16'h9ABC, "R7");
    step(0, 4'b1111, 0, 16'h0040, 16'h0055, 16'h0, "R7");
    step(0, 4'b0101, 0, 16'h0040, 16'h0000, 16'h0, "R7");
    step(1, 4'b0101, 0, 16'h0040, 16'h0000, 16'h0, "R7");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: op = 4'b0101;
        3, 4, 5: op = 4'b0110;
        6:       op = 4'b0111;
        7:       op = 4'b1111;
        default: op = 4'($urandom);
      endcase
      step(($urandom_range(0, 7) != 0), op, 1'($urandom),
           16'($urandom), 16'($urandom), 16'($urandom), "");
    end
    step(0, 4'h0, 0, 16'h0, 16'h0, 16'h0, "R8");
    step(0, 4'h0, 0, 16'h0, 16'h0, 16'h0, "R8");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule